// File: doc/BRIEF.md
# Register-Mapped GPIO Controller With Edge Events

This block gives a processor 32 general-purpose pins through six 32-bit registers on a simple word-sized register bus. Each pin is set as an input or an output. Output pins drive the level last written for them. Input pins are sampled every clock, and their level is copied into the data register.

A change on an input pin can record an event. A per-pin control bit chooses whether any change counts or only a falling edge counts. Software clears events by writing ones. A single level interrupt is high while any event bit is unmasked. An open-drain selection per pin is held in a register and brought out for an external pad model.

The bus has no handshake. A write takes effect at the clock edge where it is presented. A read returns its data one cycle after the read strobe.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: Byte offsets 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 select direction, open-drain, data, event, mask and control. A read at any other offset returns zero, and a write there changes nothing.
- R2: When `bus_word` is 0, the access is not a full word. Such a read returns zero, and such a write changes no register.
- R3: Pin n corresponds to register bit 31−n in every register, so pin 0 is the most significant bit. `pin_out[n]`, `pin_oe[n]`, `pin_od[n]` and `pin_in[n]` all follow this mapping.
- R4: After reset, all six registers read zero, and `pin_out` and `irq` are low.
- R5: The direction, open-drain, mask and control registers read back what was written. `pin_oe` shows the direction bits, where 1 means output. `pin_od` shows the open-drain bits.
- R6: A data-register write stores the full written value. `pin_out[n]` takes the written bit only when pin n is an output at that write. `pin_out` changes on no other event.
- R7: A level change on an input pin reaches its data bit two clock edges after the change is applied: one sampling edge, then one compare edge. Level changes on output pins leave the data register and the events unchanged. If a pin change and a data write reach the same input bit at the same edge, the pin level is stored.
- R8: For an input pin whose control bit is 0, a change in either direction sets its event bit.
- R9: For an input pin whose control bit is 1, only a high-to-low change sets its event bit. A rise updates the data bit but records no event.
- R10: A write to the event register clears each bit written as 1. Bits written as 0 keep their value.
- R11: If an event is set and cleared at the same edge, the bit ends up set.
- R12: `irq` is high exactly when some bit is set in both the event and the mask registers. It follows each register change with no added cycle.
- R13: Read data appears on `bus_rdata` in the cycle after `bus_rd`. It holds when no read is issued. Reads change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_word | input | 1 | 1 for a full 32-bit access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_in | input | 32 | Sampled pin levels, index = pin number |
| pin_out | output | 32 | Driven pin levels, index = pin number |
| pin_oe | output | 32 | 1 where the pin is an output |
| pin_od | output | 32 | Open-drain selection per pin |
| irq | output | 1 | Level interrupt |

## Verification
The event logic is tested with four pin patterns, each on one input pin:
- a rise with any-change capture, which must record an event;
- a fall with any-change capture, which must also record one;
- a rise then a fall with falling-only capture, where only the fall may count;
- toggles on a pin set as output, which must be ignored completely.

These patterns separate a detector that ignores direction or the control bit from a correct one. A fall on a pin whose event is already set, timed to land on the same edge as a clearing write, separates set-wins priority from clear-wins. Data values with asymmetric bit patterns on mixed input and output pins expose a reversed pin mapping, and show whether writes to input bits leak onto the pins.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  localparam logic [31:0] OFF_DIR = 32'h00;
  localparam logic [31:0] OFF_ODR = 32'h04;
  localparam logic [31:0] OFF_DAT = 32'h08;
  localparam logic [31:0] OFF_EVT = 32'h0C;
  localparam logic [31:0] OFF_MSK = 32'h10;
  localparam logic [31:0] OFF_CTL = 32'h14;

  typedef enum logic [2:0] {
    SEL_DIR,
    SEL_ODR,
    SEL_DAT,
    SEL_EVT,
    SEL_MSK,
    SEL_CTL,
    SEL_NONE
  } reg_sel_e;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
  import gpio_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic [AW-1:0] addr,
  input  logic          word,
  output reg_sel_e      sel
);

  logic [31:0] addr_ext;

  assign addr_ext = 32'(addr);

  // Partial-width accesses decode to nothing, just like unmapped offsets.
  always_comb begin
    sel = SEL_NONE;
    if (word) begin
      case (addr_ext)
        OFF_DIR: sel = SEL_DIR;
        OFF_ODR: sel = SEL_ODR;
        OFF_DAT: sel = SEL_DAT;
        OFF_EVT: sel = SEL_EVT;
        OFF_MSK: sel = SEL_MSK;
        OFF_CTL: sel = SEL_CTL;
        default: sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/gpio_pin_sense.sv
module gpio_pin_sense #(
  parameter int NP = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NP-1:0] pin_in,  // index = pin number
  input  logic [NP-1:0] dir_q,   // register order
  input  logic [NP-1:0] ctl_q,   // register order
  output logic [NP-1:0] smp_q,   // register order
  output logic [NP-1:0] ev_set,
  output logic [NP-1:0] dat_ld
);

  logic [NP-1:0] prev_q;

  for (genvar b = 0; b < NP; b++) begin : g_bit
    localparam int PIN = NP - 1 - b;
    logic chg;
    logic fall;
    logic is_in;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        smp_q[b]  <= 1'b0;
        prev_q[b] <= 1'b0;
      end else begin
        smp_q[b]  <= pin_in[PIN];
        prev_q[b] <= smp_q[b];
      end
    end

    assign chg   = smp_q[b] ^ prev_q[b];
    assign fall  = prev_q[b] & ~smp_q[b];
    assign is_in = ~dir_q[b];

    assign ev_set[b] = is_in & (ctl_q[b] ? fall : chg);
    assign dat_ld[b] = is_in & chg;
  end

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int NP = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  reg_sel_e      sel,
  input  logic [NP-1:0] wdata,
  input  logic [NP-1:0] ev_set,
  input  logic [NP-1:0] dat_ld,
  input  logic [NP-1:0] smp_q,
  output logic [NP-1:0] dir_q,
  output logic [NP-1:0] odr_q,
  output logic [NP-1:0] dat_q,
  output logic [NP-1:0] evt_q,
  output logic [NP-1:0] msk_q,
  output logic [NP-1:0] ctl_q,
  output logic [NP-1:0] drv_q
);

  logic          dat_wr;
  logic [NP-1:0] evt_clr;
  logic [NP-1:0] dat_nxt;
  logic [NP-1:0] evt_nxt;
  logic [NP-1:0] drv_nxt;

  always_comb begin
    dat_wr  = wr_en && (sel == SEL_DAT);
    evt_clr = (wr_en && (sel == SEL_EVT)) ? wdata : '0;

    // A sampled input level overrides a software write to the same bit.
    dat_nxt = dat_wr ? wdata : dat_q;
    dat_nxt = (dat_nxt & ~dat_ld) | (smp_q & dat_ld);

    // A hardware event set takes priority over a clear at the same edge.
    evt_nxt = (evt_q & ~evt_clr) | ev_set;

    // Drive levels move only on a data write, and only for output bits.
    drv_nxt = dat_wr ? ((drv_q & ~dir_q) | (wdata & dir_q)) : drv_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      odr_q <= '0;
      msk_q <= '0;
      ctl_q <= '0;
    end else if (wr_en) begin
      if (sel == SEL_DIR) dir_q <= wdata;
      if (sel == SEL_ODR) odr_q <= wdata;
      if (sel == SEL_MSK) msk_q <= wdata;
      if (sel == SEL_CTL) ctl_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      evt_q <= '0;
      drv_q <= '0;
    end else begin
      dat_q <= dat_nxt;
      evt_q <= evt_nxt;
      drv_q <= drv_nxt;
    end
  end

endmodule

// File: rtl/gpio_rd_port.sv
module gpio_rd_port
  import gpio_pkg::*;
#(
  parameter int NP = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en,
  input  reg_sel_e      sel,
  input  logic [NP-1:0] dir_q,
  input  logic [NP-1:0] odr_q,
  input  logic [NP-1:0] dat_q,
  input  logic [NP-1:0] evt_q,
  input  logic [NP-1:0] msk_q,
  input  logic [NP-1:0] ctl_q,
  output logic [NP-1:0] rdata_q
);

  logic [NP-1:0] rd_mux;

  always_comb begin
    case (sel)
      SEL_DIR: rd_mux = dir_q;
      SEL_ODR: rd_mux = odr_q;
      SEL_DAT: rd_mux = dat_q;
      SEL_EVT: rd_mux = evt_q;
      SEL_MSK: rd_mux = msk_q;
      SEL_CTL: rd_mux = ctl_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_pkg::*;
#(
  parameter int NP = 32,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_word,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [NP-1:0] bus_wdata,
  output logic [NP-1:0] bus_rdata,
  input  logic [NP-1:0] pin_in,
  output logic [NP-1:0] pin_out,
  output logic [NP-1:0] pin_oe,
  output logic [NP-1:0] pin_od,
  output logic          irq
);

  reg_sel_e      sel;
  logic [NP-1:0] dir_q, odr_q, dat_q, evt_q, msk_q, ctl_q, drv_q;
  logic [NP-1:0] smp_q, ev_set, dat_ld;

  gpio_addr_dec #(.AW(AW)) u_dec (
    .addr (bus_addr),
    .word (bus_word),
    .sel  (sel)
  );

  gpio_pin_sense #(.NP(NP)) u_sense (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_in (pin_in),
    .dir_q  (dir_q),
    .ctl_q  (ctl_q),
    .smp_q  (smp_q),
    .ev_set (ev_set),
    .dat_ld (dat_ld)
  );

  gpio_regs #(.NP(NP)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (bus_wr),
    .sel    (sel),
    .wdata  (bus_wdata),
    .ev_set (ev_set),
    .dat_ld (dat_ld),
    .smp_q  (smp_q),
    .dir_q  (dir_q),
    .odr_q  (odr_q),
    .dat_q  (dat_q),
    .evt_q  (evt_q),
    .msk_q  (msk_q),
    .ctl_q  (ctl_q),
    .drv_q  (drv_q)
  );

  gpio_rd_port #(.NP(NP)) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (bus_rd),
    .sel     (sel),
    .dir_q   (dir_q),
    .odr_q   (odr_q),
    .dat_q   (dat_q),
    .evt_q   (evt_q),
    .msk_q   (msk_q),
    .ctl_q   (ctl_q),
    .rdata_q (bus_rdata)
  );

  // Register bit NP-1-n belongs to pin n.
  for (genvar n = 0; n < NP; n++) begin : g_pin
    assign pin_out[n] = drv_q[NP-1-n];
    assign pin_oe[n]  = dir_q[NP-1-n];
    assign pin_od[n]  = odr_q[NP-1-n];
  end

  assign irq = |(evt_q & msk_q);

endmodule

// File: rtl/gpio_edge_ctrl_chk.sv
module gpio_edge_ctrl_chk #(
  parameter int NP = 32,
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_word,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [NP-1:0] bus_rdata,
  input logic [NP-1:0] pin_out,
  input logic [NP-1:0] msk_q,
  input logic          irq
);

  logic mapped;
  logic dat_write;

  assign mapped    = (bus_addr[1:0] == 2'b00) && (32'(bus_addr) <= 32'h14);
  assign dat_write = bus_wr && bus_word && (32'(bus_addr) == 32'h08);

  p_unmapped_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_word && !mapped) |=> (bus_rdata == '0));

  p_short_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_word) |=> (bus_rdata == '0));

  p_drive_only_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !dat_write |=> $stable(pin_out));

  p_no_mask_no_irq_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '0) |-> !irq);

  p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

endmodule

bind gpio_edge_ctrl gpio_edge_ctrl_chk #(.NP(NP), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_word  (bus_word),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .msk_q     (msk_q),
  .irq       (irq)
);

// File: tb/test_gpio_edge_ctrl.sv
module test_gpio_edge_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_word = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pin_out;
  logic [31:0] pin_oe;
  logic [31:0] pin_od;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  gpio_edge_ctrl i_gpio_edge_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_word  (bus_word),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .pin_od    (pin_od),
    .irq       (irq)
  );

  function automatic logic [31:0] rev(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic word = 1'b1);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_word = word; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_word = 1'b0;
  endtask

  // Driver: issues a read and pushes the expected value to the scoreboard.
  task automatic rd(input string tag, input logic [7:0] a, input logic [31:0] exp,
                    input logic word = 1'b1);
    @(negedge clk);
    bus_addr = a; bus_word = word; bus_rd = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0; bus_word = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_pin(input int p, input logic v);
    @(negedge clk);
    pin_in[p] = v;
    repeat (3) @(negedge clk);
  endtask

  // Monitor: compares read data in the cycle after each read strobe.
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R13 unexpected read got %h expected none", bus_rdata);
        end else begin
          check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 reset state
    check("R4 pin_out", pin_out, 32'h0);
    check("R4 irq", {31'b0, irq}, 32'h0);
    rd("R4 dir", 8'h00, 32'h0);
    rd("R4 odr", 8'h04, 32'h0);
    rd("R4 dat", 8'h08, 32'h0);
    rd("R4 evt", 8'h0C, 32'h0);
    rd("R4 msk", 8'h10, 32'h0);
    rd("R4 ctl", 8'h14, 32'h0);

    // R5 R3: pins 0 and 1 become outputs
    wr(8'h00, 32'hC000_0000);
    rd("R5 dir readback", 8'h00, 32'hC000_0000);
    check("R3 pin_oe mapping", pin_oe, 32'h0000_0003);
    wr(8'h04, 32'h1234_5678);
    rd("R5 odr readback", 8'h04, 32'h1234_5678);
    check("R3 pin_od mapping", pin_od, rev(32'h1234_5678));

    // R6: only output bits reach the pins
    wr(8'h08, 32'hA000_0005);
    rd("R6 dat stored", 8'h08, 32'hA000_0005);
    check("R6 pin_out outputs only", pin_out, 32'h0000_0001);
    wr(8'h08, 32'h4000_0000);
    check("R6 pin_out second write", pin_out, 32'h0000_0002);

    // R1 unmapped and misaligned
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h02, 32'hFFFF_FFFF);
    rd("R1 unmapped read", 8'h18, 32'h0);
    rd("R1 misaligned read", 8'h02, 32'h0);
    rd("R1 dir untouched", 8'h00, 32'hC000_0000);

    // R2 partial-width access
    wr(8'h10, 32'hFFFF_FFFF, 1'b0);
    rd("R2 short write ignored", 8'h10, 32'h0);
    rd("R2 short read zero", 8'h00, 32'h0, 1'b0);

    // R8 R7: pin 5 rises with any-change capture
    set_pin(5, 1'b1);
    rd("R7 dat after rise", 8'h08, 32'h4400_0000);
    rd("R8 evt after rise", 8'h0C, 32'h0400_0000);
    check("R12 irq masked off", {31'b0, irq}, 32'h0);
    wr(8'h10, 32'h0400_0000);
    check("R12 irq on", {31'b0, irq}, 32'h1);
    rd("R13 evt read no side effect", 8'h0C, 32'h0400_0000);

    // R10 write-one-to-clear
    wr(8'h0C, 32'h0000_0000);
    rd("R10 zero write keeps", 8'h0C, 32'h0400_0000);
    wr(8'h0C, 32'hFBFF_FFFF);
    rd("R10 other bits keep", 8'h0C, 32'h0400_0000);
    wr(8'h0C, 32'h0400_0000);
    rd("R10 cleared", 8'h0C, 32'h0);
    check("R12 irq off after clear", {31'b0, irq}, 32'h0);

    // R8 fall with any-change capture
    set_pin(5, 1'b0);
    rd("R8 evt after fall", 8'h0C, 32'h0400_0000);
    rd("R7 dat after fall", 8'h08, 32'h4000_0000);
    check("R12 irq on after fall", {31'b0, irq}, 32'h1);
    wr(8'h0C, 32'hFFFF_FFFF);

    // R9 falling-only on pin 7
    wr(8'h14, 32'h0100_0000);
    rd("R5 ctl readback", 8'h14, 32'h0100_0000);
    set_pin(7, 1'b1);
    rd("R9 rise no event", 8'h0C, 32'h0);
    rd("R9 rise updates dat", 8'h08, 32'h4100_0000);
    set_pin(7, 1'b0);
    rd("R9 fall event", 8'h0C, 32'h0100_0000);
    wr(8'h0C, 32'hFFFF_FFFF);

    // R7 output pin 1 ignores its input
    set_pin(1, 1'b1);
    set_pin(1, 1'b0);
    rd("R7 output pin dat", 8'h08, 32'h4000_0000);
    rd("R7 output pin evt", 8'h0C, 32'h0);
    check("R6 pin_out unchanged", pin_out, 32'h0000_0002);

    // R11 set wins over a simultaneous clear, pin 9 = bit 22
    set_pin(9, 1'b1);
    rd("R8 pin 9 rise", 8'h0C, 32'h0040_0000);
    @(negedge clk);
    pin_in[9] = 1'b0;
    wr(8'h0C, 32'h0040_0000);
    repeat (2) @(negedge clk);
    rd("R11 set wins", 8'h0C, 32'h0040_0000);
    wr(8'h0C, 32'h0040_0000);
    rd("R11 later clear", 8'h0C, 32'h0);

    // R12 mask selects which events interrupt
    set_pin(9, 1'b1);
    check("R12 unmasked event no irq", {31'b0, irq}, 32'h0);
    wr(8'h10, 32'h0040_0000);
    check("R12 masked event irq", {31'b0, irq}, 32'h1);

    repeat (2) @(negedge clk);
    check("R13 scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule